// File: doc/BRIEF.md
# Complex Bit-Stream Channel Filter

This block is the digital channel filter that sits behind a complex sigma-delta converter in a low-IF receiver. It takes two 1-bit streams, one on the in-phase path and one on the quadrature path. It applies a complex FIR response whose passband sits on the positive intermediate frequency only. The image band at the negative IF, neighbouring interferers and the shaped quantisation noise at high frequency all fall into the stopband.

The complex response is made from four real FIR sums: the real coefficient set applied to each path and the imaginary coefficient set applied to each path. These four sums are cross-combined into the filtered I and Q outputs. Every input bit stands for +1 or -1, so each tap adds or subtracts its coefficient and the block needs no multiplier. The coefficients are fixed at build time through parameters. The default set is a triangular window turned to a quarter of the Nyquist band, so that it passes +fs/8 and rejects -fs/8.

Both sides of the block use valid/ready handshakes. An input pair is taken on a clock edge where `in_valid` and `in_ready` are both high. Its filtered result is held in a single output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the result stays frozen and no new input is taken, so back-pressure passes straight to the source.

Top module: `cplx_bitstream_fir`

## Requirements
- R1: An input bit of 1 weighs its tap by +1 and a bit of 0 weighs it by -1. With I held at all ones and Q at all zeros over the full tap span, `out_i` = sum(Hr) + sum(Hi) and `out_q` = sum(Hi) - sum(Hr).
- R2: `out_i` equals the sum over taps k of I[k]*Hr[k] minus the sum of Q[k]*Hi[k], exact and sign-correct.
- R3: `out_q` equals the sum over taps k of I[k]*Hi[k] plus the sum of Q[k]*Hr[k], exact and sign-correct.
- R4: Tap 0 holds the most recently accepted sample and tap k holds the sample accepted k acceptances earlier. Coefficient k is the CW-bit field at bit offset k*CW of the coefficient parameter.
- R5: A sample is taken only on a clock edge where `in_valid` and `in_ready` are both high. At any other edge both delay lines keep their contents, whatever the data inputs carry.
- R6: After an accepting edge, `out_valid` is high from the next cycle and the outputs carry that sample's result. With no acceptance and `out_ready` high, `out_valid` drops on the next edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_i` and `out_q` hold their values.
- R8: `in_ready` is high exactly when the output register is empty or `out_ready` is high. A sample offered during a stall is taken on the edge where the stall ends.
- R9: A synchronous reset clears `out_valid`. It sets tap k of both delay lines to 1 for even k and to 0 for odd k.
- R10: The output width CW + log2(N) + 2 holds the largest result without overflow. With both inputs at all ones, `out_i` = sum(Hr) - sum(Hi) and `out_q` = sum(Hr) + sum(Hi), exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take an input pair this cycle |
| in_i | input | 1 | In-phase modulator bit |
| in_q | input | 1 | Quadrature modulator bit |
| out_valid | output | 1 | Filtered pair present |
| out_ready | input | 1 | Consumer takes the filtered pair |
| out_i | output | OW | Filtered in-phase sample, signed |
| out_q | output | OW | Filtered quadrature sample, signed |

## Verification
The hardest case to reach from the ports is a stall that overlaps a new offer. The output register is full and `out_ready` is low, while the source keeps `in_valid` high with a fresh bit pair. For those cycles the block must neither shift its delay lines nor disturb the held result. The stall task sets up exactly this state and keeps it for several cycles. It then releases `out_ready` in the same cycle as the waiting offer, so the release edge must take the sample and publish its result together. A behavioural tap model in the bench then predicts the exact sums on random streams, after gaps in `in_valid`, and after reset.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  localparam int DEF_TAPS = 32;
  localparam int DEF_CW   = 12;

  // cos(pi*k/4) scaled by 256
  function automatic int rot_q8(input int k);
    case (k % 8)
      0:       return 256;
      1:       return 181;
      2:       return 0;
      3:       return -181;
      4:       return -256;
      5:       return -181;
      6:       return 0;
      default: return 181;
    endcase
  endfunction

  // Triangular window rotated to +fs/8: real part uses cos, imaginary part uses sin
  function automatic logic [DEF_TAPS*DEF_CW-1:0] default_coefs(input bit imag);
    logic [DEF_TAPS*DEF_CW-1:0] v;
    int w;
    int c;
    int h;
    v = '0;
    for (int k = 0; k < DEF_TAPS; k++) begin
      w = (k + 1 < DEF_TAPS - k) ? k + 1 : DEF_TAPS - k;
      c = imag ? rot_q8(k + 6) : rot_q8(k);
      h = (w * 127 * c) >>> 8;
      v[k*DEF_CW +: DEF_CW] = h[DEF_CW-1:0];
    end
    return v;
  endfunction

endpackage

// File: rtl/cfir_bitline.sv
module cfir_bitline #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         din,
  output logic [N-1:0] taps_nxt,
  output logic [N-1:0] taps
);

  logic [N-1:0] rst_pat;

  for (genvar k = 0; k < N; k++) begin : g_pat
    assign rst_pat[k] = ((k % 2) == 0);
  end

  if (N > 1) begin : g_multi
    assign taps_nxt = shift ? {taps[N-2:0], din} : taps;
  end else begin : g_single
    assign taps_nxt = shift ? din : taps;
  end

  always_ff @(posedge clk) begin
    if (rst) taps <= rst_pat;
    else     taps <= taps_nxt;
  end

  // R5: no shift, no change
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(taps));

  // R4: newest sample lands in tap 0
  p_newest_tap0_r4: assert property (@(posedge clk) disable iff (rst)
    shift |=> taps[0] == $past(din));

  // R9: reset pattern
  p_reset_pattern_r9: assert property (@(posedge clk)
    rst |=> taps == rst_pat);

endmodule

// File: rtl/cfir_tapsum.sv
module cfir_tapsum #(
  parameter int             N    = 32,
  parameter int             CW   = 12,
  parameter int             SW   = 18,
  parameter logic [N*CW-1:0] COEF = '0
) (
  input  logic [N-1:0]         bits,
  output logic signed [SW-1:0] sum
);

  always_comb begin : b_acc
    logic signed [SW-1:0] c_ext;
    sum = '0;
    for (int k = 0; k < N; k++) begin
      c_ext = SW'(signed'(COEF[k*CW +: CW]));
      if (bits[k]) sum = sum + c_ext;
      else         sum = sum - c_ext;
    end
  end

endmodule

// File: rtl/cplx_bitstream_fir.sv
module cplx_bitstream_fir #(
  parameter int              N   = cfir_pkg::DEF_TAPS,
  parameter int              CW  = cfir_pkg::DEF_CW,
  parameter logic [N*CW-1:0] HR  = cfir_pkg::default_coefs(1'b0),
  parameter logic [N*CW-1:0] HI  = cfir_pkg::default_coefs(1'b1),
  localparam int             AW  = (N > 1) ? $clog2(N) : 1,
  localparam int             OW  = CW + AW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_i,
  input  logic                 in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);

  localparam int SW = CW + AW + 1;

  logic         accept;
  logic [1:0]   lane_bit;
  logic [N-1:0] lane_nxt [2];
  logic [N-1:0] lane_reg [2];
  // sums[lane][set]: lane 0 = I, 1 = Q; set 0 = Hr, 1 = Hi
  logic signed [SW-1:0] sums [2][2];
  logic signed [OW-1:0] res_i;
  logic signed [OW-1:0] res_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign lane_bit = {in_q, in_i};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    cfir_bitline #(.N(N)) u_line (
      .clk      (clk),
      .rst      (rst),
      .shift    (accept),
      .din      (lane_bit[g]),
      .taps_nxt (lane_nxt[g]),
      .taps     (lane_reg[g])
    );
    for (genvar s = 0; s < 2; s++) begin : g_set
      cfir_tapsum #(
        .N    (N),
        .CW   (CW),
        .SW   (SW),
        .COEF ((s == 0) ? HR : HI)
      ) u_sum (
        .bits (lane_nxt[g]),
        .sum  (sums[g][s])
      );
    end
  end

  // complex product: (I + jQ)(Hr + jHi)
  assign res_i = OW'(sums[0][0]) - OW'(sums[1][1]);
  assign res_q = OW'(sums[0][1]) + OW'(sums[1][0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_i     <= res_i;
      out_q     <= res_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: accepted sample appears next cycle
  p_result_next_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R6: drained with nothing new leaves the register empty
  p_drain_empty_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid && out_ready |=> !out_valid);

  // R7: stalled result is frozen
  p_stall_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

endmodule

// File: tb/cplx_bitstream_fir_bench.sv
module cplx_bitstream_fir_bench;

  localparam int N  = 32;
  localparam int CW = 12;
  localparam int OW = CW + $clog2(N) + 2;

  function automatic int coef_r(input int k);
    return ((k % 3) == 0) ? -2048 + 5 * k : 2047 - 37 * k;
  endfunction

  function automatic int coef_i(input int k);
    return ((k % 4) == 1) ? 1900 - 11 * k : -2048 + 61 * k;
  endfunction

  function automatic logic [N*CW-1:0] pack_coefs(input bit imag);
    logic [N*CW-1:0] v;
    int h;
    v = '0;
    for (int k = 0; k < N; k++) begin
      h = imag ? coef_i(k) : coef_r(k);
      v[k*CW +: CW] = h[CW-1:0];
    end
    return v;
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_i = 1'b0;
  logic in_q = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [OW-1:0] out_i;
  logic signed [OW-1:0] out_q;

  always #4 clk = ~clk;

  cplx_bitstream_fir #(
    .N  (N),
    .CW (CW),
    .HR (pack_coefs(1'b0)),
    .HI (pack_coefs(1'b1))
  ) u_cplx_bitstream_fir (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  int vectors = 0;
  int fails   = 0;
  bit mi [N];
  bit mq [N];

  task automatic chk(input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      mi[k] = ((k % 2) == 0);
      mq[k] = ((k % 2) == 0);
    end
  endtask

  task automatic model_shift(input bit bi, input bit bq);
    for (int k = N - 1; k > 0; k--) begin
      mi[k] = mi[k-1];
      mq[k] = mq[k-1];
    end
    mi[0] = bi;
    mq[0] = bq;
  endtask

  function automatic int exp_i();
    int a;
    a = 0;
    for (int k = 0; k < N; k++)
      a += (mi[k] ? coef_r(k) : -coef_r(k)) - (mq[k] ? coef_i(k) : -coef_i(k));
    return a;
  endfunction

  function automatic int exp_q();
    int a;
    a = 0;
    for (int k = 0; k < N; k++)
      a += (mi[k] ? coef_i(k) : -coef_i(k)) + (mq[k] ? coef_r(k) : -coef_r(k));
    return a;
  endfunction

  function automatic int sum_r();
    int a;
    a = 0;
    for (int k = 0; k < N; k++) a += coef_r(k);
    return a;
  endfunction

  function automatic int sum_i();
    int a;
    a = 0;
    for (int k = 0; k < N; k++) a += coef_i(k);
    return a;
  endfunction

  // one isolated sample, checked the cycle after acceptance
  task automatic push(input bit bi, input bit bq, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_i = bi; in_q = bq; out_ready = 1'b1;
    @(posedge clk);
    model_shift(bi, bq);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, int'(out_valid), 1);
    chk({req, " out_i"}, int'(out_i), exp_i());
    chk({req, " out_q"}, int'(out_q), exp_q());
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R9 out_valid after reset", int'(out_valid), 0);
    chk("R8 in_ready when empty", int'(in_ready), 1);
    push(1'b1, 1'b1, "R9 first sample over reset pattern");
  endtask

  task automatic t_constant();
    for (int n = 0; n < N; n++) push(1'b1, 1'b0, "R4 fill");
    chk("R1 ones/zeros out_i", int'(out_i), sum_r() + sum_i());
    chk("R1 ones/zeros out_q", int'(out_q), sum_i() - sum_r());
  endtask

  task automatic t_fullscale();
    for (int n = 0; n < N; n++) push(1'b1, 1'b1, "R10 fill");
    chk("R10 all ones out_i", int'(out_i), sum_r() - sum_i());
    chk("R10 all ones out_q", int'(out_q), sum_r() + sum_i());
  endtask

  // back-to-back stream with valid held high
  task automatic t_stream(input int count);
    bit bi;
    bit bq;
    @(negedge clk);
    out_ready = 1'b1;
    bi = 1'($urandom); bq = 1'($urandom);
    in_valid = 1'b1; in_i = bi; in_q = bq;
    for (int n = 0; n < count; n++) begin
      @(posedge clk);
      model_shift(bi, bq);
      @(negedge clk);
      chk("R6 stream out_valid", int'(out_valid), 1);
      chk("R2 stream out_i", int'(out_i), exp_i());
      chk("R3 stream out_q", int'(out_q), exp_q());
      bi = 1'($urandom); bq = 1'($urandom);
      in_i = bi; in_q = bq;
    end
    in_valid = 1'b0;
  endtask

  task automatic t_gaps();
    push(1'b0, 1'b1, "R2 before gap");
    @(negedge clk);
    for (int n = 0; n < 5; n++) begin
      in_i = 1'($urandom); in_q = 1'($urandom);
      @(negedge clk);
      chk("R6 out_valid drops without input", int'(out_valid), 0);
    end
    push(1'b1, 1'b0, "R5 after gap, lines unchanged");
  endtask

  task automatic t_stall();
    int held_i;
    int held_q;
    @(negedge clk);
    in_valid = 1'b1; in_i = 1'b0; in_q = 1'b0; out_ready = 1'b0;
    @(posedge clk);
    model_shift(1'b0, 1'b0);
    @(negedge clk);
    in_i = 1'b1; in_q = 1'b0;
    chk("R8 in_ready low while stalled", int'(in_ready), 0);
    chk("R7 out_valid in stall", int'(out_valid), 1);
    chk("R2 stalled out_i", int'(out_i), exp_i());
    chk("R3 stalled out_q", int'(out_q), exp_q());
    held_i = int'(out_i);
    held_q = int'(out_q);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R7 out_valid held", int'(out_valid), 1);
      chk("R7 out_i held", int'(out_i), held_i);
      chk("R7 out_q held", int'(out_q), held_q);
      chk("R8 in_ready held low", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    #1;
    chk("R8 in_ready rises with out_ready", int'(in_ready), 1);
    @(posedge clk);
    model_shift(1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 offer taken at release out_valid", int'(out_valid), 1);
    chk("R8 offer taken at release out_i", int'(out_i), exp_i());
    chk("R8 offer taken at release out_q", int'(out_q), exp_q());
  endtask

  initial begin : main
    t_reset_state();
    t_constant();
    t_fullscale();
    t_stream(300);
    t_gaps();
    t_stall();
    t_stream(100);
    t_reset_state();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule